// File: doc/BRIEF.md
# Serial Random Bitstream Health Monitor

The block watches a raw random bit source one bit at a time and flags statistical defects as they appear. Bits arrive with a valid strobe. Every 20,000 accepted bits form one window. At the end of each window the block judges three properties of that window: the balance of ones against zeros, the spread of 4-bit symbol frequencies, and the distribution of run lengths. Separately, and with no regard to window edges, it raises an alarm when a run of identical bits grows to 34, and a second, stronger alarm when it grows to 48.

A second input path accepts the wide output words of the generator that uses this source. The block raises a strobe whenever an accepted word equals the word accepted just before it. Each defect is reported as a single-cycle strobe, one clock after the bit or word that completes it. A status collector samples these strobes.

Top module: `rng_health_mon`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every failure strobe is low.
- R2: At a window end, `ones_fail_o` pulses if the number of ones in the window is not strictly greater than 9654 and strictly less than 10346.
- R3: The window is split into 5000 aligned, non-overlapping nibbles. The first bit of each nibble is its most significant bit. `poker_fail_o` pulses at the window end unless both of these hold: (a) 16 times the sum of the squared nibble counts, minus 25,000,000, lies strictly between 5150 and 287,000; (b) each of the 16 nibble counts lies within 200..450 inclusive.
- R4: Runs inside a window are tallied separately for zeros and ones, in the classes 1, 2, 3, 4, 5 and 6-or-more. A run still open at the window end is closed there, and the next window starts a fresh run. `runs_fail_o` pulses at the window end unless every tally lies within its inclusive bounds: 2267..2733, 1079..1421, 502..748, 223..402, 90..223 and 90..223 for the six classes in that order.
- R5: The three window strobes are high only in the cycle after the 20,000th bit of a window is accepted, and only for that one cycle. All window tallies then restart from zero.
- R6: `long_run_o` pulses once, in the cycle after the bit that makes 34 consecutive identical bits is accepted. Runs are counted across window ends.
- R7: `noise_o` pulses once, in the cycle after the bit that makes 48 consecutive identical bits is accepted. It pulses again only after the run has been broken.
- R8: `stuck_o` pulses in the cycle after an accepted word equals the previously accepted word. The first word after reset never triggers it, and cycles without a word valid do not reset the comparison.
- R9: Cycles with `bit_valid_i` low change no tally and do not break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Raw bit accepted this cycle |
| bit_i | input | 1 | Raw bit value |
| word_valid_i | input | 1 | Output word accepted this cycle |
| word_i | input | WORD_W | Output word value |
| ones_fail_o | output | 1 | Window ones-balance failure strobe |
| poker_fail_o | output | 1 | Window nibble-frequency failure strobe |
| runs_fail_o | output | 1 | Window run-length distribution failure strobe |
| long_run_o | output | 1 | 34-bit identical run strobe |
| noise_o | output | 1 | 48-bit identical run strobe |
| stuck_o | output | 1 | Repeated output word strobe |

## Verification
Five consecutive windows are driven with distinct bit patterns. A pseudo-random stream with idle gaps should pass all window tests and shows that gaps are transparent. A stream biased toward ones separates the balance test from a stream that is merely patterned. A strictly alternating stream has exactly 10,000 ones, yet it must fail the nibble and run tests. Two further windows carry forced runs: one of about 40 ones that straddles a window end, which must trigger only the 34-bit alarm, and one of 60 zeros, which must trigger both alarms. A short sequence of repeated and differing words, with an idle cycle between repeats, covers the word comparison.

// File: rtl/rng_hm_pkg.sv
package rng_hm_pkg;
  localparam int RUN_CLS = 6;

  // inclusive pass bounds per run class (1..5, 6+)
  function automatic int run_lo(int cls);
    case (cls)
      0: run_lo = 2267;
      1: run_lo = 1079;
      2: run_lo = 502;
      3: run_lo = 223;
      default: run_lo = 90;
    endcase
  endfunction

  function automatic int run_hi(int cls);
    case (cls)
      0: run_hi = 2733;
      1: run_hi = 1421;
      2: run_hi = 748;
      3: run_hi = 402;
      default: run_hi = 223;
    endcase
  endfunction
endpackage

// File: rtl/rng_hm_freq.sv
module rng_hm_freq #(
  parameter int WIN_BITS   = 20000,
  parameter int MONO_LO    = 9654,
  parameter int MONO_HI    = 10346,
  parameter int PK_X_LO    = 5150,
  parameter int PK_X_HI    = 287000,
  parameter int PK_CNT_MIN = 200,
  parameter int PK_CNT_MAX = 450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic last_i,
  output logic ones_fail_o,
  output logic poker_fail_o
);
  localparam int CW   = $clog2(WIN_BITS + 1);
  localparam int NIBS = WIN_BITS / 4;
  localparam int PW   = $clog2(NIBS + 1);
  localparam int SW   = 2 * PW + 4;
  localparam int XW   = SW + 4;
  localparam logic [XW-1:0] PK_OFS = XW'(longint'(NIBS) * longint'(NIBS));

  logic [CW-1:0] ones_q, ones_d;
  logic [2:0]    sh_q;
  logic [1:0]    npos_q;
  logic [SW-1:0] sumsq_q, sumsq_d;
  logic [PW-1:0] cnt_q [16];
  logic [PW-1:0] cnt_d [16];
  logic          hit_w;
  logic [3:0]    idx_w;
  logic [XW-1:0] x_w;
  logic          cnt_ok_w;

  assign hit_w = npos_q == 2'd3;
  assign idx_w = {sh_q, bit_i};
  assign ones_d = ones_q + CW'(bit_i);
  // running sum of squares: (c+1)^2 - c^2 = 2c+1
  assign sumsq_d = sumsq_q + (hit_w ? SW'({cnt_q[idx_w], 1'b1}) : '0);
  assign x_w = {sumsq_d, 4'b0000} - PK_OFS;

  for (genvar k = 0; k < 16; k++) begin : g_sym
    logic [PW-1:0] c_q;
    assign cnt_q[k] = c_q;
    assign cnt_d[k] = c_q + PW'(hit_w && (idx_w == 4'(k)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          c_q <= '0;
      else if (bit_valid_i) c_q <= last_i ? '0 : cnt_d[k];
    end
  end

  always_comb begin
    cnt_ok_w = 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (cnt_d[k] < PW'(PK_CNT_MIN) || cnt_d[k] > PW'(PK_CNT_MAX)) cnt_ok_w = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q       <= '0;
      sh_q         <= '0;
      npos_q       <= '0;
      sumsq_q      <= '0;
      ones_fail_o  <= 1'b0;
      poker_fail_o <= 1'b0;
    end else begin
      ones_fail_o  <= 1'b0;
      poker_fail_o <= 1'b0;
      if (bit_valid_i) begin
        sh_q <= {sh_q[1:0], bit_i};
        if (last_i) begin
          ones_q       <= '0;
          npos_q       <= '0;
          sumsq_q      <= '0;
          ones_fail_o  <= !(ones_d > CW'(MONO_LO) && ones_d < CW'(MONO_HI));
          poker_fail_o <= !(x_w > XW'(PK_X_LO) && x_w < XW'(PK_X_HI) && cnt_ok_w);
        end else begin
          ones_q  <= ones_d;
          npos_q  <= npos_q + 2'd1;
          sumsq_q <= sumsq_d;
        end
      end
    end
  end

  AST_ONES_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q < CW'(WIN_BITS)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> $stable(ones_q) && $stable(sumsq_q)); // R9
endmodule

// File: rtl/rng_hm_runs.sv
module rng_hm_runs
  import rng_hm_pkg::*;
#(
  parameter int WIN_BITS  = 20000,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic last_i,
  output logic runs_fail_o,
  output logic long_run_o,
  output logic noise_o
);
  localparam int CW = $clog2(WIN_BITS + 1);
  localparam int LW = $clog2(NOISE_RUN + 1);

  logic          last_q, have_q;
  logic [LW-1:0] len_q, len_d;
  logic [2:0]    wlen_q, wlen_d;
  logic          same_w, wcont_w, runs_ok_w;
  logic [CW-1:0] rc_q [2][RUN_CLS];
  logic [CW-1:0] rc_d [2][RUN_CLS];

  // continuous run, saturating so each alarm fires once per run
  assign same_w = have_q && (bit_i == last_q);
  assign len_d  = !same_w ? LW'(1) : (len_q == LW'(NOISE_RUN) ? len_q : len_q + LW'(1));

  // window run, restarted at each window end
  assign wcont_w = (wlen_q != 3'd0) && (bit_i == last_q);
  assign wlen_d  = !wcont_w ? 3'd1 : (wlen_q == 3'd6 ? 3'd6 : wlen_q + 3'd1);

  always_comb begin
    rc_d = rc_q;
    if (!wcont_w && wlen_q != 3'd0)
      rc_d[last_q][wlen_q - 3'd1] = rc_q[last_q][wlen_q - 3'd1] + CW'(1);
    // closing run at the end has opposite polarity or is the same run
    if (last_i)
      rc_d[bit_i][wlen_d - 3'd1] = rc_d[bit_i][wlen_d - 3'd1] + CW'(1);
    runs_ok_w = 1'b1;
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < RUN_CLS; c++) begin
        if (rc_d[b][c] < CW'(run_lo(c)) || rc_d[b][c] > CW'(run_hi(c))) runs_ok_w = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q      <= 1'b0;
      have_q      <= 1'b0;
      len_q       <= '0;
      wlen_q      <= '0;
      runs_fail_o <= 1'b0;
      long_run_o  <= 1'b0;
      noise_o     <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < RUN_CLS; c++) rc_q[b][c] <= '0;
    end else begin
      runs_fail_o <= 1'b0;
      long_run_o  <= 1'b0;
      noise_o     <= 1'b0;
      if (bit_valid_i) begin
        last_q     <= bit_i;
        have_q     <= 1'b1;
        len_q      <= len_d;
        long_run_o <= same_w && (len_q == LW'(LONG_RUN - 1));
        noise_o    <= same_w && (len_q == LW'(NOISE_RUN - 1));
        if (last_i) begin
          wlen_q      <= '0;
          runs_fail_o <= !runs_ok_w;
          for (int b = 0; b < 2; b++)
            for (int c = 0; c < RUN_CLS; c++) rc_q[b][c] <= '0;
        end else begin
          wlen_q <= wlen_d;
          rc_q   <= rc_d;
        end
      end
    end
  end

  AST_LONG_AT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_run_o |-> len_q == LW'(LONG_RUN)); // R6
  AST_LONG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_run_o |=> !long_run_o); // R6
  AST_NOISE_AT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_o |-> len_q == LW'(NOISE_RUN)); // R7
  AST_RUN_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> $stable(len_q) && $stable(wlen_q)); // R9
endmodule

// File: rtl/rng_hm_stuck.sv
module rng_hm_stuck #(
  parameter int WORD_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              stuck_o
);
  logic [WORD_W-1:0] prev_q;
  logic              have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      stuck_o <= 1'b0;
    end else begin
      stuck_o <= word_valid_i && have_q && (word_i == prev_q);
      if (word_valid_i) begin
        prev_q <= word_i;
        have_q <= 1'b1;
      end
    end
  end

  AST_STUCK_NEEDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_o |-> $past(word_valid_i)); // R8
endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon #(
  parameter int WIN_BITS  = 20000,
  parameter int WORD_W    = 128,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ones_fail_o,
  output logic              poker_fail_o,
  output logic              runs_fail_o,
  output logic              long_run_o,
  output logic              noise_o,
  output logic              stuck_o
);
  localparam int CW = $clog2(WIN_BITS + 1);

  logic [CW-1:0] pos_q;
  logic          last_w;

  assign last_w = bit_valid_i && (pos_q == CW'(WIN_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pos_q <= '0;
    else if (bit_valid_i) pos_q <= last_w ? '0 : pos_q + CW'(1);
  end

  rng_hm_freq #(.WIN_BITS(WIN_BITS)) u_freq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_valid_i  (bit_valid_i),
    .bit_i        (bit_i),
    .last_i       (last_w),
    .ones_fail_o  (ones_fail_o),
    .poker_fail_o (poker_fail_o)
  );

  rng_hm_runs #(.WIN_BITS(WIN_BITS), .LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_runs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .last_i      (last_w),
    .runs_fail_o (runs_fail_o),
    .long_run_o  (long_run_o),
    .noise_o     (noise_o)
  );

  rng_hm_stuck #(.WORD_W(WORD_W)) u_stuck (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .stuck_o      (stuck_o)
  );

  AST_WIN_STROBE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_fail_o || poker_fail_o || runs_fail_o) |-> $past(last_w)); // R5
  AST_POS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < CW'(WIN_BITS)); // R5
endmodule

// File: tb/rng_health_mon_test.sv
module rng_health_mon_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bit_valid_i = 1'b0;
  logic         bit_i = 1'b0;
  logic         word_valid_i = 1'b0;
  logic [127:0] word_i = '0;
  logic ones_fail_o, poker_fail_o, runs_fail_o, long_run_o, noise_o, stuck_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rng_health_mon uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_valid_i(bit_valid_i), .bit_i(bit_i),
    .word_valid_i(word_valid_i), .word_i(word_i),
    .ones_fail_o(ones_fail_o), .poker_fail_o(poker_fail_o), .runs_fail_o(runs_fail_o),
    .long_run_o(long_run_o), .noise_o(noise_o), .stuck_o(stuck_o)
  );

  // bench model state
  logic [31:0] rs = 32'h1234_5678;
  int m_ones, m_nib, m_pos, m_wlen, m_wval, m_len, m_last;
  bit m_have = 1'b0;
  int m_pk [16];
  int m_rc [2][6];

  function automatic int lo_b(int c);
    int t [6] = '{2267, 1079, 502, 223, 90, 90};
    return t[c];
  endfunction
  function automatic int hi_b(int c);
    int t [6] = '{2733, 1421, 748, 402, 223, 223};
    return t[c];
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input bit force_cnt);
    if (force_cnt || act || exp) begin
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
    end
  endtask

  task automatic clear_window();
    m_ones = 0; m_nib = 0; m_pos = 0; m_wlen = 0; m_wval = 0;
    for (int k = 0; k < 16; k++) m_pk[k] = 0;
    for (int b = 0; b < 2; b++) for (int c = 0; c < 6; c++) m_rc[b][c] = 0;
  endtask

  function automatic bit rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs[31];
  endfunction

  // one cycle: drive at negedge, check at next negedge
  task automatic step(input bit v, input bit b);
    bit e_one, e_pk, e_run, e_long, e_noise, at_end, same;
    longint sq, x;
    e_one = 0; e_pk = 0; e_run = 0; e_long = 0; e_noise = 0; at_end = 0;
    bit_valid_i = v;
    bit_i = b;
    if (v) begin
      same = m_have && (int'(b) == m_last);
      e_long  = same && (m_len == 33);
      e_noise = same && (m_len == 47);
      m_len = same ? ((m_len < 48) ? m_len + 1 : 48) : 1;
      m_last = int'(b);
      m_have = 1'b1;
      m_ones += int'(b);
      m_nib = ((m_nib << 1) | int'(b)) & 15;
      m_pos++;
      if (m_pos % 4 == 0) m_pk[m_nib]++;
      if (m_wlen > 0 && int'(b) == m_wval) m_wlen++;
      else begin
        if (m_wlen > 0) m_rc[m_wval][((m_wlen < 6) ? m_wlen : 6) - 1]++;
        m_wlen = 1;
        m_wval = int'(b);
      end
      if (m_pos == 20000) begin
        at_end = 1;
        m_rc[m_wval][((m_wlen < 6) ? m_wlen : 6) - 1]++;
        e_one = !(m_ones > 9654 && m_ones < 10346);
        sq = 0;
        for (int k = 0; k < 16; k++) begin
          sq += longint'(m_pk[k]) * longint'(m_pk[k]);
          if (m_pk[k] < 200 || m_pk[k] > 450) e_pk = 1;
        end
        x = 16 * sq - 64'd25000000;
        if (!(x > 5150 && x < 287000)) e_pk = 1;
        for (int bb = 0; bb < 2; bb++)
          for (int c = 0; c < 6; c++)
            if (m_rc[bb][c] < lo_b(c) || m_rc[bb][c] > hi_b(c)) e_run = 1;
        clear_window();
      end
    end
    @(negedge clk);
    if (at_end) begin
      chk(ones_fail_o, e_one, "R2 ones balance at window end", 1);
      chk(poker_fail_o, e_pk, "R3 nibble frequency at window end", 1);
      chk(runs_fail_o, e_run, "R4 run distribution at window end", 1);
    end else begin
      chk(ones_fail_o, 1'b0, v ? "R5 ones strobe off window end" : "R9 idle cycle ones strobe", 0);
      chk(poker_fail_o, 1'b0, v ? "R5 poker strobe off window end" : "R9 idle cycle poker strobe", 0);
      chk(runs_fail_o, 1'b0, v ? "R5 runs strobe off window end" : "R9 idle cycle runs strobe", 0);
    end
    chk(long_run_o, e_long, v ? "R6 long run" : "R9 idle cycle long run", 0);
    chk(noise_o, e_noise, v ? "R7 noise run" : "R9 idle cycle noise", 0);
    chk(stuck_o, 1'b0, "R8 stuck without word", 0);
  endtask

  // kind: 0 random, 1 biased, 2 alternating, 3 random ending in ones, 4 ones head + zero burst
  task automatic send_window(input int kind, input bit gaps);
    bit b;
    for (int i = 0; i < 20000; i++) begin
      case (kind)
        1:       b = rnd() | (i % 4 == 0);
        2:       b = bit'(i % 2);
        3:       b = (i >= 19970) ? 1'b1 : rnd();
        4:       b = (i < 10) ? 1'b1 : ((i >= 5000 && i < 5060) ? 1'b0 : rnd());
        default: b = rnd();
      endcase
      if (gaps && (i % 7 == 3)) step(1'b0, ~b); // R9: idle cycle with opposite bit
      step(1'b1, b);
    end
  endtask

  task automatic t_reset();
    // R1
    chk(ones_fail_o, 1'b0, "R1 reset ones", 1);
    chk(poker_fail_o, 1'b0, "R1 reset poker", 1);
    chk(runs_fail_o, 1'b0, "R1 reset runs", 1);
    chk(long_run_o, 1'b0, "R1 reset long", 1);
    chk(noise_o, 1'b0, "R1 reset noise", 1);
    chk(stuck_o, 1'b0, "R1 reset stuck", 1);
  endtask

  task automatic word_step(input bit v, input logic [127:0] w, input logic exp);
    word_valid_i = v;
    word_i = w;
    @(negedge clk);
    chk(stuck_o, exp, "R8 repeated word", 1);
  endtask

  task automatic t_stuck();
    logic [127:0] wa, wb;
    wa = {4{32'hA5A5_0F0F}};
    wb = {4{32'h1357_9BDF}};
    word_step(1'b1, wb, 1'b0); // first word after reset
    word_step(1'b1, wa, 1'b0);
    word_step(1'b1, wa, 1'b1);
    word_step(1'b0, wb, 1'b0);
    word_step(1'b1, wa, 1'b1); // idle cycle keeps previous word
    word_step(1'b1, wb, 1'b0);
    word_valid_i = 1'b0;
  endtask

  initial begin
    clear_window();
    m_len = 0; m_last = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_stuck();
    send_window(0, 1'b1);
    send_window(1, 1'b0);
    send_window(2, 1'b0);
    send_window(3, 1'b0);
    send_window(4, 1'b0);
    bit_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule